// File: doc/BRIEF.md
# Fixed-Priority Hold-Until-Release Arbiter

This block shares a single resource among three requesters. Each requester raises its own request line and keeps it high for as long as it needs the resource. The block answers with a one-hot grant vector. When no grant is outstanding, the arbiter looks at the pending requests and picks one by fixed priority. Requester 0 (`req[0]`) has the highest priority and requester 2 has the lowest.

A grant is never taken away. The granted requester keeps the resource until it lowers its own request, whatever the other lines do in the meantime. On release the controller spends one cycle with no grant before it arbitrates again. Two grants therefore never sit on adjacent cycles, which gives the resource one clean cycle between owners.

The controller is a Moore machine with four states: one idle state and one ownership state per requester. The grant outputs are decoded from the state register alone. Reset is synchronous and active high.

Top module: `prio_hold_arbiter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `gnt` is 3'b000 after that edge, whatever the requests are.
- R2: With no grant outstanding and `req` equal to 3'b000, `gnt` stays 3'b000 after the next edge.
- R3: With no grant outstanding and `req[0]` high, `gnt` becomes 3'b001 after the next edge, whatever `req[2:1]` are.
- R4: With no grant outstanding, `req[0]` low and `req[1]` high, `gnt` becomes 3'b010 after the next edge.
- R5: With no grant outstanding and `req` equal to 3'b100, `gnt` becomes 3'b100 after the next edge.
- R6: While the granted requester keeps its own request bit high, `gnt` stays unchanged, even when a higher-priority request is raised.
- R7: When the granted requester's request bit is low at an edge, `gnt` is 3'b000 after that edge, even if other requests are pending.
- R8: `gnt` has at most one bit set in every cycle.
- R9: `gnt` never moves directly from one nonzero value to a different nonzero value. At least one all-zero cycle lies between two different grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 3 | Request lines; bit 0 has the highest priority, bit 2 the lowest |
| gnt | output | 3 | One-hot grant, decoded from the state register |

## Verification
The bench builds the block with the package's default of three requesters. With that setting, all eight request patterns can be applied from the idle state and from each of the three ownership states. This reaches every priority decision, every hold and every release, including releases while higher-priority or lower-priority requests are pending. Random traffic holds each request line for several cycles, so long ownerships and preemption attempts occur often. Directed sequences also apply a reset in the middle of a grant and apply every request pattern to the idle state.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_REQ = 3;
    localparam int ST_W    = $clog2(NUM_REQ + 1);

    typedef logic [NUM_REQ-1:0] req_vec_t;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 2'd0,
        ST_OWN0 = 2'd1,
        ST_OWN1 = 2'd2,
        ST_OWN2 = 2'd3
    } arb_state_e;

    // Ownership state for requester idx
    function automatic arb_state_e own_state(int idx);
        return arb_state_e'(ST_W'(idx + 1));
    endfunction

    // Fixed priority: lowest index wins
    function automatic arb_state_e pick_state(req_vec_t r);
        arb_state_e s;
        s = ST_IDLE;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (r[i]) s = own_state(i);
        end
        return s;
    endfunction

    // One-hot view of which requester owns the resource in a state
    function automatic req_vec_t state_onehot(arb_state_e s);
        req_vec_t v;
        for (int i = 0; i < NUM_REQ; i++) begin
            v[i] = (s == own_state(i));
        end
        return v;
    endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import arb_pkg::*;
(
    input  req_vec_t   req,
    output arb_state_e winner
);
    always_comb begin
        winner = pick_state(req);
    end
endmodule

// File: rtl/arb_next_state.sv
module arb_next_state
    import arb_pkg::*;
(
    input  arb_state_e cur,
    input  req_vec_t   req,
    input  arb_state_e winner,
    output arb_state_e nxt
);
    logic owner_holds;

    always_comb begin
        owner_holds = |(state_onehot(cur) & req);
        if (cur == ST_IDLE) begin
            nxt = winner;
        end else if (owner_holds) begin
            nxt = cur;
        end else begin
            nxt = ST_IDLE;
        end
    end
endmodule

// File: rtl/arb_grant_dec.sv
module arb_grant_dec
    import arb_pkg::*;
(
    input  arb_state_e state,
    output req_vec_t   gnt
);
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
        assign gnt[g] = (state == own_state(g));
    end
endmodule

// File: rtl/prio_hold_arbiter.sv
module prio_hold_arbiter
    import arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt
);
    arb_state_e state_q;
    arb_state_e state_d;
    arb_state_e winner;

    arb_prio_pick u_pick (
        .req    (req),
        .winner (winner)
    );

    arb_next_state u_next (
        .cur    (state_q),
        .req    (req),
        .winner (winner),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    arb_grant_dec u_dec (
        .state (state_q),
        .gnt   (gnt)
    );
endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req,
    input logic [NUM_REQ-1:0] gnt
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (gnt == '0));

    assert_idle_stays_R2: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0 && req == '0) |=> (gnt == '0));

    assert_top_prio_R3: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0 && req[0]) |=> (gnt == 3'b001));

    assert_mid_prio_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0 && req[1:0] == 2'b10) |=> (gnt == 3'b010));

    assert_low_prio_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0 && req == 3'b100) |=> (gnt == 3'b100));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (|(gnt & req)) |=> (gnt == $past(gnt)));

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && (gnt & req) == '0) |=> (gnt == '0));

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_idle_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && gnt != $past(gnt)) |-> ($past(gnt) == '0));
endmodule

bind prio_hold_arbiter arb_checker u_arb_checker (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
);

// File: tb/prio_hold_arbiter_tb_top.sv
module prio_hold_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req = 3'b000;
    logic [2:0] gnt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [2:0] exp_gnt  = 3'b000;
    logic [2:0] prev_gnt = 3'b000;
    string      tag      = "R1";

    always #5 clk = ~clk;

    prio_hold_arbiter dut_i (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
    );

    // Expected grant from the requirements
    function automatic logic [2:0] prio_of(logic [2:0] r);
        if (r[0]) return 3'b001;
        if (r[1]) return 3'b010;
        if (r[2]) return 3'b100;
        return 3'b000;
    endfunction

    function automatic string rule_of(logic rs, logic [2:0] cur, logic [2:0] r);
        if (rs) return "R1";
        if (cur == 3'b000) begin
            if (r == 3'b000) return "R2";
            if (r[0]) return "R3";
            if (r[1]) return "R4";
            return "R5";
        end
        if ((cur & r) != 3'b000) return "R6";
        return "R7";
    endfunction

    function automatic logic [2:0] next_exp(logic rs, logic [2:0] cur, logic [2:0] r);
        if (rs) return 3'b000;
        if (cur == 3'b000) return prio_of(r);
        if ((cur & r) != 3'b000) return cur;
        return 3'b000;
    endfunction

    task automatic check(string t, logic [2:0] act, logic [2:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: gnt actual %b expected %b", t, act, expv);
        end
    endtask

    task automatic cycle(logic [2:0] r, logic rs);
        req = r;
        rst = rs;
        tag = rule_of(rs, exp_gnt, r);
        exp_gnt = next_exp(rs, exp_gnt, r);
        @(posedge clk);
        @(negedge clk);
        check(tag, gnt, exp_gnt);
        checks++;
        if ($countones(gnt) > 1) begin
            errors++;
            $display("FAIL R8: gnt actual %b expected at most one bit", gnt);
        end
        checks++;
        if (!rs && gnt != 3'b000 && prev_gnt != 3'b000 && gnt != prev_gnt) begin
            errors++;
            $display("FAIL R9: gnt actual %b expected 000 or %b", gnt, prev_gnt);
        end
        prev_gnt = gnt;
    endtask

    initial begin
        logic [2:0] cur_req;
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset with requests pending
        cycle(3'b111, 1'b1);
        cycle(3'b111, 1'b1);
        // R2: idle with nothing pending
        cycle(3'b000, 1'b0);
        cycle(3'b000, 1'b0);
        // R3 then R6 hold
        cycle(3'b111, 1'b0);
        cycle(3'b111, 1'b0);
        // R7: owner 0 drops while others wait
        cycle(3'b110, 1'b0);
        // R4
        cycle(3'b110, 1'b0);
        // R6: higher priority arrives, no preemption
        cycle(3'b011, 1'b0);
        cycle(3'b111, 1'b0);
        // R7 then R5
        cycle(3'b100, 1'b0);
        cycle(3'b100, 1'b0);
        cycle(3'b101, 1'b0);
        cycle(3'b111, 1'b0);
        // R1: reset mid-grant
        cycle(3'b111, 1'b1);
        cycle(3'b000, 1'b0);
        // every pattern from idle (R2..R5)
        for (int p = 0; p < 8; p++) begin
            cycle(3'(p), 1'b0);
            cycle(3'b000, 1'b0);
            cycle(3'b000, 1'b0);
        end
        // random traffic with held requests
        cur_req = 3'b000;
        for (int k = 0; k < 400; k++) begin
            for (int b = 0; b < 3; b++) begin
                if ($urandom_range(0, 3) == 0) cur_req[b] = ~cur_req[b];
            end
            cycle(cur_req, ($urandom_range(0, 99) == 0));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule